// File: doc/BRIEF.md
# Block Erase Fill Engine

This block is a write-only memory master that stands in for a flash block erase inside a storage emulator. The emulated flash content lives in a large memory reached over an AXI4 link. An erase is modelled by overwriting the whole block region with the erased byte value. The caller gives a start address and a byte count, which is the page length times the number of pages in a block and is often several megabytes. A one-cycle start strobe launches the fill.

The engine needs no data source. Every write beat carries one erased byte replicated across the bus, taken from an internal fill register. That register comes out of reset as all ones and may be reloaded while the engine is idle. The region is cut into many separate AXI4 INCR bursts. Each burst is capped at a configurable maximum packet size, and no burst runs past a 4 KB address boundary. Keeping bursts short lets the shared link interleave traffic from other channels between them. The bus width is a parameter. It must be wide enough that block_bytes / (clock rate × erase time) bytes move per cycle.

The region can end part-way through a bus word. In that case the final beat enables only the low byte lanes still owed. Completion is reported only when every write response has come back. Any error response leaves an error flag set, and that flag stays set until the next erase is accepted.

Top module: `ef_block_erase_fill`

## Requirements
- R1: After reset the engine is idle: busy, done, error, AWVALID and WVALID are all low, and the fill byte is 0xFF.
- R2: One erase writes exactly block_bytes strobed bytes. The bursts are contiguous: the first starts at the start address and each later one starts where the previous burst's bytes ended.
- R3: No burst carries more than MAX_BURST_BYTES bytes, counted as (AWLEN+1) × bus bytes.
- R4: No burst crosses a BOUNDARY (4096-byte) aligned address.
- R5: Every beat enables all byte lanes except the final beat of an erase whose size is not a multiple of the bus width. That beat enables only the low (size mod bus bytes) lanes, where lane i is WSTRB bit i and holds address offset i.
- R6: Every beat's data is the fill byte replicated on all lanes. A fill-register write is taken only while idle; one requested during an erase has no effect on that erase or on the stored value.
- R7: AWBURST is INCR (2'b01), AWSIZE equals log2(bus bytes), AWLEN is the beat count minus one, and WLAST is high exactly on a burst's final beat.
- R8: done pulses high for a single cycle, and only after the write response of every burst of the erase has been accepted. busy stays high from the accepted start until that pulse.
- R9: A write response of SLVERR (2'b10) or DECERR (2'b11) sets the error output. The flag holds through the done pulse and afterwards, and clears only when the next start is accepted. OKAY responses never set it.
- R10: A start strobe while busy is ignored. It produces no extra burst and no extra done pulse.
- R11: A start with a byte count of zero issues no burst and pulses done in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Erase launch strobe, taken only when idle |
| start_addr_i | input | ADDR_W | First byte address of the block, aligned to the bus width |
| block_bytes_i | input | SIZE_W | Bytes to fill (pages per block × page length) |
| fill_wr_i | input | 1 | Load the fill register, taken only when idle |
| fill_val_i | input | 8 | New erased byte value |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky error from a failed write response |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Beats in burst minus one |
| m_awsize | output | 3 | log2 of bytes per beat |
| m_awburst | output | 2 | Burst type, always INCR |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Replicated fill byte |
| m_wstrb | output | DATA_W/8 | Byte lane enables |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready, always high |
| m_bresp | input | 2 | Write response code |

## Verification
The embedded assertions assume three things about the inputs. The start address is a multiple of the bus width. The memory side never returns a write response for a burst that has not been issued. It also never has more responses outstanding than the engine allows. The stimulus only uses start addresses that are multiples of eight. Its memory model queues a response only when it accepts the WLAST beat of a burst, and it returns queued responses one at a time after a random delay. The address- and data-ready signals are toggled pseudo-randomly, so the bursts hold their values under back-pressure, and the chosen sizes include boundary-straddling starts and partial tails.

// File: rtl/ef_pkg.sv
// Shared definitions for the block erase fill engine.
// Assumes AXI4 encodings for burst type and response codes.
package ef_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_DRAIN,
        ST_FIN
    } ef_state_e;

    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;
endpackage

// File: rtl/ef_burst_plan.sv
// Burst planner: from the low address bits and the bytes still owed, picks
// the size of the next burst, limited by the packet cap and by the distance
// to the next boundary. Purely combinational.
// Assumes the address is aligned to the bus width and MAX_BURST_BYTES is a
// multiple of the bus width, so only the final burst can end mid-word.
module ef_burst_plan #(
    parameter int SIZE_W          = 32,
    parameter int BYTES           = 8,
    parameter int MAX_BURST_BYTES = 256,
    parameter int BOUNDARY        = 4096
) (
    input  logic [$clog2(BOUNDARY)-1:0] addr_lo,
    input  logic [SIZE_W-1:0]           remain,
    output logic [SIZE_W-1:0]           chunk,
    output logic [7:0]                  len,
    output logic [$clog2(BYTES)-1:0]    tail
);
    localparam int OFF_W = $clog2(BYTES);

    logic [SIZE_W-1:0] room;
    logic [SIZE_W-1:0] cap;

    // Pick the smallest of owed bytes, packet cap and room to the boundary.
    always_comb begin
        room  = SIZE_W'(BOUNDARY) - SIZE_W'(addr_lo);
        cap   = (room < SIZE_W'(MAX_BURST_BYTES)) ? room : SIZE_W'(MAX_BURST_BYTES);
        chunk = (remain < cap) ? remain : cap;
        len   = 8'((chunk + SIZE_W'(BYTES - 1)) >> OFF_W) - 8'd1;
        tail  = chunk[OFF_W-1:0];
    end
endmodule

// File: rtl/ef_beat_gen.sv
// Write beat generator: once loaded with a burst length and tail byte count,
// drives WVALID for that many beats, raising WLAST and the partial strobe on
// the final one. Data itself comes from the top level.
// Assumes a new load arrives only after the previous burst has finished.
module ef_beat_gen #(
    parameter int BYTES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [7:0]               load_len,
    input  logic [$clog2(BYTES)-1:0] load_tail,
    input  logic                     wready,
    output logic                     wvalid,
    output logic                     wlast,
    output logic [BYTES-1:0]         wstrb,
    output logic                     burst_end
);
    localparam int OFF_W = $clog2(BYTES);

    logic             active_q;
    logic [7:0]       left_q;
    logic [OFF_W-1:0] tail_q;
    logic [BYTES-1:0] last_strb;

    // Count down the beats of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            left_q   <= '0;
            tail_q   <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            left_q   <= load_len;
            tail_q   <= load_tail;
        end else if (wvalid && wready) begin
            if (left_q == 8'd0) active_q <= 1'b0;
            else                left_q   <= left_q - 8'd1;
        end
    end

    // Lane enables for the final beat: low tail lanes, or all if tail is zero.
    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            last_strb[i] = (tail_q == '0) || (OFF_W'(i) < tail_q);
        end
    end

    // Beat-level outputs.
    always_comb begin
        wvalid    = active_q;
        wlast     = active_q && (left_q == 8'd0);
        wstrb     = wlast ? last_strb : {BYTES{1'b1}};
        burst_end = wvalid && wready && wlast;
    end

    a_r5_full_lanes_midburst: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wlast |-> (&wstrb));
    a_r7_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(wstrb) && $stable(wlast));
    a_r7_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active_q);
endmodule

// File: rtl/ef_resp_track.sv
// Response tracker: counts bursts issued but not yet answered and keeps a
// sticky error flag that clears when a new erase is accepted.
// Assumes responses only arrive for issued bursts.
module ef_resp_track #(
    parameter int MAX_OUTST = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       issue,
    input  logic       ret,
    input  logic [1:0] resp,
    output logic       idle,
    output logic       full,
    output logic       err
);
    import ef_pkg::*;

    localparam int OUT_W = $clog2(MAX_OUTST + 1);

    logic [OUT_W-1:0] cnt_q;
    logic             err_q;

    // Outstanding burst count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({issue, ret})
                2'b10:   cnt_q <= cnt_q + OUT_W'(1);
                2'b01:   cnt_q <= cnt_q - OUT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Sticky error flag, cleared when a new erase starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                                               err_q <= 1'b0;
        else if (clear)                                           err_q <= 1'b0;
        else if (ret && (resp == RESP_SLVERR || resp == RESP_DECERR)) err_q <= 1'b1;
    end

    assign idle = (cnt_q == '0);
    assign full = (cnt_q == OUT_W'(MAX_OUTST));
    assign err  = err_q;

    a_r8_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        ret |-> (cnt_q != '0));
    a_r8_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= OUT_W'(MAX_OUTST));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !clear |=> err_q);
endmodule

// File: rtl/ef_block_erase_fill.sv
// Block erase fill engine top: accepts an erase request, walks the region in
// planned bursts, issues each address then its beats, waits for all write
// responses and pulses done. Data is the fill byte replicated.
// Assumes start_addr_i aligned to DATA_W/8 and MAX_BURST_BYTES <= 256 beats.
module ef_block_erase_fill #(
    parameter int ADDR_W          = 32,
    parameter int SIZE_W          = 32,
    parameter int DATA_W          = 64,
    parameter int MAX_BURST_BYTES = 256,
    parameter int BOUNDARY        = 4096,
    parameter int MAX_OUTST       = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   start_addr_i,
    input  logic [SIZE_W-1:0]   block_bytes_i,
    input  logic                fill_wr_i,
    input  logic [7:0]          fill_val_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_wvalid,
    input  logic                m_wready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    input  logic                m_bvalid,
    output logic                m_bready,
    input  logic [1:0]          m_bresp
);
    import ef_pkg::*;

    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);
    localparam int BND_W = $clog2(BOUNDARY);

    ef_state_e         st_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [SIZE_W-1:0] remain_q;
    logic [7:0]        fill_q;

    logic [SIZE_W-1:0] chunk;
    logic [7:0]        plan_len;
    logic [OFF_W-1:0]  plan_tail;
    logic              aw_hs;
    logic              accept;
    logic              burst_end;
    logic              resp_idle;
    logic              resp_full;

    // Plan the next burst from the current position.
    ef_burst_plan #(
        .SIZE_W(SIZE_W), .BYTES(BYTES),
        .MAX_BURST_BYTES(MAX_BURST_BYTES), .BOUNDARY(BOUNDARY)
    ) u_plan (
        .addr_lo(cur_addr_q[BND_W-1:0]), .remain(remain_q),
        .chunk(chunk), .len(plan_len), .tail(plan_tail)
    );

    // Generate the write beats of each accepted burst.
    ef_beat_gen #(.BYTES(BYTES)) u_beats (
        .clk(clk), .rst_n(rst_n), .load(aw_hs), .load_len(plan_len),
        .load_tail(plan_tail), .wready(m_wready), .wvalid(m_wvalid),
        .wlast(m_wlast), .wstrb(m_wstrb), .burst_end(burst_end)
    );

    // Track outstanding responses and the error flag.
    ef_resp_track #(.MAX_OUTST(MAX_OUTST)) u_resp (
        .clk(clk), .rst_n(rst_n), .clear(accept), .issue(aw_hs),
        .ret(m_bvalid && m_bready), .resp(m_bresp),
        .idle(resp_idle), .full(resp_full), .err(err_o)
    );

    // Handshake and channel outputs.
    always_comb begin
        accept    = (st_q == ST_IDLE) && start_i;
        m_awvalid = (st_q == ST_ADDR) && !resp_full;
        aw_hs     = m_awvalid && m_awready;
        m_awaddr  = cur_addr_q;
        m_awlen   = plan_len;
        m_awsize  = 3'(OFF_W);
        m_awburst = BURST_INCR;
        m_wdata   = {BYTES{fill_q}};
        m_bready  = 1'b1;
        busy_o    = (st_q != ST_IDLE);
        done_o    = (st_q == ST_FIN);
    end

    // Erase sequencing: address phase, data phase, response drain, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cur_addr_q <= '0;
            remain_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start_i) begin
                    cur_addr_q <= start_addr_i;
                    remain_q   <= block_bytes_i;
                    st_q       <= (block_bytes_i == '0) ? ST_FIN : ST_ADDR;
                end
                ST_ADDR: if (aw_hs) begin
                    cur_addr_q <= cur_addr_q + ADDR_W'(chunk);
                    remain_q   <= remain_q - chunk;
                    st_q       <= ST_DATA;
                end
                ST_DATA: if (burst_end) begin
                    st_q <= (remain_q == '0) ? ST_DRAIN : ST_ADDR;
                end
                ST_DRAIN: if (resp_idle) st_q <= ST_FIN;
                ST_FIN:   st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Fill register: reloadable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  fill_q <= 8'hFF;
        else if (!busy_o && fill_wr_i) fill_q <= fill_val_i;
    end

    a_r2_start_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (start_addr_i[OFF_W-1:0] == '0));
    a_r3_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (((SIZE_W'(m_awlen) + 1) << OFF_W) <= SIZE_W'(MAX_BURST_BYTES)));
    a_r4_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> ((SIZE_W'(m_awaddr[BND_W-1:0]) + ((SIZE_W'(m_awlen) + 1) << OFF_W))
                       <= SIZE_W'(BOUNDARY)));
    a_r7_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));
    a_r8_done_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> resp_idle && !m_wvalid && !m_awvalid);
    a_r6_fill_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(fill_q));
    a_r10_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !aw_hs |=> $stable(remain_q) && $stable(cur_addr_q));
endmodule

// File: tb/ef_block_erase_fill_tb.sv
// Scoreboard bench: the erase task pushes expected bursts, the monitor pops
// and compares each address handshake and every data beat.
module ef_block_erase_fill_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 32;
    localparam int DATA_W = 64;
    localparam int BYTES  = 8;
    localparam int MAXB   = 256;
    localparam int BND    = 4096;

    typedef struct {
        logic [31:0] addr;
        int          len;
        int          tail;
    } burst_t;

    logic clk, rst_n;
    logic start_i, fill_wr_i;
    logic [ADDR_W-1:0] start_addr_i;
    logic [SIZE_W-1:0] block_bytes_i;
    logic [7:0] fill_val_i;
    logic busy_o, done_o, err_o;
    logic m_awvalid, m_awready;
    logic [ADDR_W-1:0] m_awaddr;
    logic [7:0] m_awlen;
    logic [2:0] m_awsize;
    logic [1:0] m_awburst;
    logic m_wvalid, m_wready, m_wlast;
    logic [DATA_W-1:0] m_wdata;
    logic [BYTES-1:0] m_wstrb;
    logic m_bvalid, m_bready;
    logic [1:0] m_bresp;

    burst_t     exp_q[$];
    logic [1:0] b_q[$];
    int checks = 0, fails = 0;
    int w_left = 0, w_tail = 0, bytes_seen = 0, done_seen = 0, burst_idx = 0;
    int inject_at = -1;
    logic [1:0] inject_resp = 2'b00;
    logic [7:0] exp_fill = 8'hFF;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 0;

    ef_block_erase_fill u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .block_bytes_i(block_bytes_i), .fill_wr_i(fill_wr_i), .fill_val_i(fill_val_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Monitor and memory model: randomised readies, queued responses.
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (m_bvalid && m_bready) m_bvalid = 1'b0;
            if (!m_bvalid && b_q.size() > 0 && lfsr[3]) begin
                m_bvalid = 1'b1;
                m_bresp  = b_q.pop_front();
            end
            m_awready = lfsr[0] | lfsr[1];
            if (m_awvalid && m_awready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R10", "unexpected burst address", m_awaddr, 0);
                end else begin
                    burst_t e;
                    e = exp_q.pop_front();
                    check(m_awaddr == e.addr, "R2", "burst address", m_awaddr, e.addr);
                    check(int'(m_awlen) == e.len, "R7", "AWLEN", m_awlen, e.len);
                    check(m_awsize == 3'd3 && m_awburst == 2'b01, "R7", "AWSIZE/AWBURST",
                          {m_awsize, m_awburst}, {3'd3, 2'b01});
                    check((int'(m_awlen) + 1) * BYTES <= MAXB, "R3", "burst bytes",
                          (int'(m_awlen) + 1) * BYTES, MAXB);
                    check(int'(m_awaddr % BND) + (int'(m_awlen) + 1) * BYTES <= BND, "R4",
                          "burst end offset", int'(m_awaddr % BND) + (int'(m_awlen) + 1) * BYTES, BND);
                    w_left = e.len + 1;
                    w_tail = e.tail;
                end
            end
            m_wready = lfsr[2] | lfsr[4];
            if (m_wvalid && m_wready) begin
                if (w_left == 0) begin
                    check(0, "R2", "beat outside burst", m_wstrb, 0);
                end else begin
                    logic [7:0] es;
                    es = (w_left == 1 && w_tail != 0) ? 8'((1 << w_tail) - 1) : 8'hFF;
                    check(m_wstrb == es, "R5", "WSTRB", m_wstrb, es);
                    check(m_wlast == (w_left == 1), "R7", "WLAST", m_wlast, w_left == 1);
                    check(m_wdata == {8{exp_fill}}, "R6", "WDATA", m_wdata, {8{exp_fill}});
                    bytes_seen += $countones(m_wstrb);
                    w_left--;
                    if (w_left == 0) begin
                        b_q.push_back(burst_idx == inject_at ? inject_resp : 2'b00);
                        burst_idx++;
                    end
                end
            end
            if (done_o) done_seen++;
        end
    end

    // Driver: push expected bursts, launch the erase, check completion.
    task automatic erase(logic [31:0] addr, int size, int inj_at, logic [1:0] inj,
                         bit exp_err, bit poke_busy);
        logic [31:0] a = addr;
        int rem = size;
        while (rem > 0) begin
            burst_t e;
            int room = BND - int'(a % BND);
            int b = rem;
            if (b > MAXB) b = MAXB;
            if (b > room) b = room;
            e.addr = a;
            e.len  = (b + BYTES - 1) / BYTES - 1;
            e.tail = b % BYTES;
            exp_q.push_back(e);
            a   += b;
            rem -= b;
        end
        burst_idx = 0; inject_at = inj_at; inject_resp = inj;
        bytes_seen = 0; done_seen = 0;
        @(negedge clk);
        start_i = 1'b1; start_addr_i = addr; block_bytes_i = size;
        @(negedge clk);
        start_i = 1'b0;
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            // R10: start during busy; R6: fill write during busy
            start_i = 1'b1; start_addr_i = addr + 32'h0010_0000; block_bytes_i = 64;
            fill_wr_i = 1'b1; fill_val_i = ~exp_fill;
            @(negedge clk);
            start_i = 1'b0; fill_wr_i = 1'b0;
        end
        do begin
            @(negedge clk);
            #1;
        end while (!done_o);
        check(bytes_seen == size, "R2", "strobed bytes", bytes_seen, size);
        check(exp_q.size() == 0, "R2", "bursts missing", exp_q.size(), 0);
        check(b_q.size() == 0 && !m_bvalid, "R8", "responses pending at done", b_q.size(), 0);
        check(err_o == exp_err, "R9", "error at done", err_o, exp_err);
        @(negedge clk);
        #1;
        check(!done_o && !busy_o, "R8", "done width / busy", {done_o, busy_o}, 0);
        check(done_seen == 1, "R10", "done pulses", done_seen, 1);
        repeat (10) @(negedge clk);
        check(err_o == exp_err, "R9", "error held", err_o, exp_err);
        check(!m_awvalid && !busy_o, "R10", "idle after done", {m_awvalid, busy_o}, 0);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; fill_wr_i = 1'b0; fill_val_i = '0;
        start_addr_i = '0; block_bytes_i = '0;
        m_awready = 1'b0; m_wready = 1'b0; m_bvalid = 1'b0; m_bresp = 2'b00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!busy_o && !done_o && !err_o, "R1", "status after reset", {busy_o, done_o, err_o}, 0);
        check(!m_awvalid && !m_wvalid, "R1", "valids after reset", {m_awvalid, m_wvalid}, 0);
        // R1: fill byte 0xFF is checked by the first erase's data
        erase(32'h0000_1000, 1024, -1, 2'b00, 0, 0);
        erase(32'h0000_1F80, 600, -1, 2'b00, 0, 0);    // R4 boundary start
        erase(32'h0000_3000, 4100, -1, 2'b00, 0, 0);   // R5 tail of 4
        erase(32'h0000_5FF8, 13, -1, 2'b00, 0, 0);     // R4/R5 tail of 5
        erase(32'h0001_0000, 1024, 1, 2'b10, 1, 0);    // R9 SLVERR
        erase(32'h0002_0000, 512, 0, 2'b11, 1, 0);     // R9 DECERR
        erase(32'h0002_1000, 256, -1, 2'b00, 0, 0);    // R9 cleared by start
        @(negedge clk);
        fill_wr_i = 1'b1; fill_val_i = 8'hA5;
        @(negedge clk);
        fill_wr_i = 1'b0; exp_fill = 8'hA5;
        erase(32'h0003_0000, 2048, -1, 2'b00, 0, 1);   // R6 value, R10 restart
        erase(32'h0003_4000, 264, -1, 2'b00, 0, 0);    // R6 busy write was ignored
        // R11: zero-size erase
        @(negedge clk);
        start_i = 1'b1; start_addr_i = 32'h0004_0000; block_bytes_i = 0;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(done_o == 1'b1, "R11", "done after zero-size start", done_o, 1);
        @(negedge clk);
        #1;
        check(!done_o && !busy_o, "R11", "zero-size single pulse", {done_o, busy_o}, 0);
        repeat (5) @(negedge clk);
        erase(32'h0008_0000, 32768, -1, 2'b00, 0, 0);  // R2 long erase
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R8 completion): actual timeout expected done");
        report();
    end
endmodule